// File: doc/BRIEF.md
# DDR2 Mode Register Command Decoder

This block sits beside a DDR2 memory controller's command output and watches the command bus on every rising clock edge. When it sees a mode-register-set command, it finds out which of the four mode registers is the target. It then checks whether the command may legally be issued at that moment. For the main mode register, it also decodes the address bus into a shadow copy of the settings. These settings are burst length, burst ordering, CAS latency, write recovery for auto-precharge, DLL reset, test mode and active power-down exit speed.

A command is accepted only when the block is not inside the post-write settling window. It also needs clock enable high, every bank precharged and no reserved encoding. The block flags three kinds of fault separately: a write attempted in the wrong device state, any command inside the settling window, and a reserved or forbidden field value. The test-mode bit is legal but unusual, so it raises a separate warning. Other logic uses the decoded outputs to set up read latency, burst counters and auto-precharge timing. Writes to the three extended registers are checked and reported but are not decoded.

Top module: `ddr2_mrs_decoder`

## Requirements
- R1: A command is a mode-register write when cs_n, ras_n, cas_n and we_n are all sampled low. If it is accepted, mrs_accept pulses and reg_sel takes ba[1:0]: 0 is the main register, 1 to 3 are extended registers 1 to 3.
- R2: A mode-register write that arrives with cke low, or with any bit of bank_open set, is refused. err_state pulses, and reg_sel and the shadow stay unchanged.
- R3: After an accepted write, busy is high for exactly TMRD cycles. Any command other than NOP (cs_n low, ras_n/cas_n/we_n high) or deselect (cs_n high) sampled while busy is high pulses err_timing and is ignored.
- R4: Burst length field A[2:0]: 3'b010 gives burst_len 4 and 3'b011 gives burst_len 8. Every other code is reserved.
- R5: A3 sets burst_interleave: 0 is sequential and 1 is interleaved. Both values are accepted with either burst length.
- R6: CAS latency field A[6:4]: codes 3 to 7 give cas_latency 3 to 7. Codes 0 to 2 are reserved.
- R7: Write recovery field A[11:9]: code c in 1 to 7 gives write_recovery c+1, so 2 to 8 cycles. Code 0 is reserved.
- R8: An accepted main-register write stores A7 as test_mode and A8 as dll_reset. When A7 is 1, warn_test pulses together with mrs_accept.
- R9: A12 sets pd_slow_exit: 0 is fast exit and 1 is slow exit. A main-register write with A13 set, or any write with ba[2] set, is reserved.
- R10: After reset mr_valid is 0. It becomes 1 after the first accepted main-register write and then stays 1. Extended-register writes never change the main shadow.
- R11: A write with a reserved encoding is refused. err_reserved pulses, the shadow and reg_sel stay unchanged, and busy does not start.
- R12: mrs_accept, err_state, err_timing, err_reserved and warn_test are one-cycle pulses in the cycle after the sampled command. At most one of the first four is high at a time. Decoded outputs change only together with mrs_accept, so the register can be rewritten whenever the rules allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as driven to the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address / register select |
| addr | input | ADDR_W | Address bus carrying register contents |
| bank_open | input | NUM_BANKS | One bit per bank, 1 = bank open |
| mr_valid | output | 1 | Main-register shadow holds written data |
| burst_len | output | 4 | Burst length in beats (4 or 8) |
| burst_interleave | output | 1 | 1 = interleaved ordering |
| cas_latency | output | 4 | CAS latency in cycles |
| write_recovery | output | 4 | Write recovery in cycles |
| dll_reset | output | 1 | DLL reset bit of the main register |
| test_mode | output | 1 | Test-mode bit of the main register |
| pd_slow_exit | output | 1 | 1 = slow power-down exit |
| reg_sel | output | 2 | Register targeted by the last accepted write |
| mrs_accept | output | 1 | Pulse: write accepted |
| busy | output | 1 | Settling window after an accepted write |
| err_state | output | 1 | Pulse: write in illegal device state |
| err_timing | output | 1 | Pulse: command during settling window |
| err_reserved | output | 1 | Pulse: reserved encoding refused |
| warn_test | output | 1 | Pulse: test mode bit written as 1 |

## Verification
The bench builds the block with TMRD set to 3 instead of its default of 2. Busy must then span three sampled edges, which separates a correct window from one that is a cycle short or a cycle long. Violations can be placed at the start and the middle of the window, and a NOP can be tested inside it. NUM_BANKS is kept at 8, so the open-bank test can set a bank bit well away from bit 0. The address width stays at 14, so A13 is present and its reserved check can be tested.

// File: rtl/ddr2_mrs_pkg.sv
`timescale 1ns/1ps
package ddr2_mrs_pkg;

    // Field positions on the address bus (decoded by the memory device)
    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int TM_BIT  = 7;
    localparam int DLL_BIT = 8;
    localparam int WR_LSB  = 9;
    localparam int PD_BIT  = 12;
    localparam int MR_HI   = 13;

    typedef enum logic [1:0] {
        SEL_MAIN = 2'd0,
        SEL_EXT1 = 2'd1,
        SEL_EXT2 = 2'd2,
        SEL_EXT3 = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_MRS,
        CMD_OTHER
    } cmd_e;

    typedef struct packed {
        logic [3:0] burst_len;
        logic       interleave;
        logic [3:0] cas_lat;
        logic [3:0] wr_cyc;
        logic       dll_reset;
        logic       test_mode;
        logic       pd_slow;
    } mr_cfg_t;

    typedef struct packed {
        logic bl;
        logic cl;
        logic wr;
        logic hi_addr;
        logic hi_bank;
    } rsv_t;

    function automatic logic [3:0] bl_beats(input logic [2:0] code);
        case (code)
            3'b010:  return 4'd4;
            3'b011:  return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] cl_cycles(input logic [2:0] code);
        return (code >= 3'd3) ? {1'b0, code} : 4'd0;
    endfunction

    function automatic logic [3:0] wr_cycles(input logic [2:0] code);
        return (code != 3'd0) ? ({1'b0, code} + 4'd1) : 4'd0;
    endfunction

endpackage

// File: rtl/mrs_cmd_decode.sv
`timescale 1ns/1ps
module mrs_cmd_decode
    import ddr2_mrs_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n)
            cmd = CMD_DESEL;
        else if (ras_n && cas_n && we_n)
            cmd = CMD_NOP;
        else if (!ras_n && !cas_n && !we_n)
            cmd = CMD_MRS;
        else
            cmd = CMD_OTHER;
    end
endmodule

// File: rtl/mrs_field_decode.sv
`timescale 1ns/1ps
module mrs_field_decode
    import ddr2_mrs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] ba,
    output mr_cfg_t           cfg,
    output rsv_t              rsv,
    output logic              rsv_hit
);
    logic hi_addr_nz;
    logic hi_bank_nz;
    logic to_main;

    generate
        if (ADDR_W > MR_HI) begin : g_hi_addr
            assign hi_addr_nz = |addr[ADDR_W-1:MR_HI];
        end else begin : g_no_hi_addr
            assign hi_addr_nz = 1'b0;
        end
        if (BANK_W > 2) begin : g_hi_bank
            assign hi_bank_nz = |ba[BANK_W-1:2];
        end else begin : g_no_hi_bank
            assign hi_bank_nz = 1'b0;
        end
    endgenerate

    assign to_main = (reg_sel_e'(ba[1:0]) == SEL_MAIN);

    always_comb begin
        cfg.burst_len  = bl_beats(addr[BL_LSB +: 3]);
        cfg.interleave = addr[BT_BIT];
        cfg.cas_lat    = cl_cycles(addr[CL_LSB +: 3]);
        cfg.wr_cyc     = wr_cycles(addr[WR_LSB +: 3]);
        cfg.dll_reset  = addr[DLL_BIT];
        cfg.test_mode  = addr[TM_BIT];
        cfg.pd_slow    = addr[PD_BIT];

        rsv.bl      = to_main && (cfg.burst_len == 4'd0);
        rsv.cl      = to_main && (cfg.cas_lat == 4'd0);
        rsv.wr      = to_main && (cfg.wr_cyc == 4'd0);
        rsv.hi_addr = to_main && hi_addr_nz;
        rsv.hi_bank = hi_bank_nz;
        rsv_hit     = |rsv;
    end
endmodule

// File: rtl/mrs_tmrd_timer.sv
`timescale 1ns/1ps
module mrs_tmrd_timer #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(TMRD + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TMRD);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_V;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/ddr2_mrs_decoder.sv
`timescale 1ns/1ps
module ddr2_mrs_decoder
    import ddr2_mrs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 14,
    parameter int BANK_W    = 3,
    parameter int TMRD      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_W-1:0]    ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 mr_valid,
    output logic [3:0]           burst_len,
    output logic                 burst_interleave,
    output logic [3:0]           cas_latency,
    output logic [3:0]           write_recovery,
    output logic                 dll_reset,
    output logic                 test_mode,
    output logic                 pd_slow_exit,
    output logic [1:0]           reg_sel,
    output logic                 mrs_accept,
    output logic                 busy,
    output logic                 err_state,
    output logic                 err_timing,
    output logic                 err_reserved,
    output logic                 warn_test
);
    cmd_e    cmd;
    mr_cfg_t cfg_new;
    mr_cfg_t cfg_q;
    rsv_t    rsv;
    logic    rsv_hit;

    logic    cmd_live;
    logic    dev_ready;
    logic    v_timing;
    logic    v_state;
    logic    v_rsv;
    logic    ok;

    mrs_cmd_decode u_cmd (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    mrs_field_decode #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_fields (
        .addr    (addr),
        .ba      (ba),
        .cfg     (cfg_new),
        .rsv     (rsv),
        .rsv_hit (rsv_hit)
    );

    mrs_tmrd_timer #(
        .TMRD (TMRD)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (ok),
        .busy (busy)
    );

    // Command qualification: timing window first, then device state, then encoding
    always_comb begin
        cmd_live  = (cmd == CMD_MRS) || (cmd == CMD_OTHER);
        dev_ready = cke && (bank_open == '0);
        v_timing  = busy && cmd_live;
        v_state   = !busy && (cmd == CMD_MRS) && !dev_ready;
        v_rsv     = !busy && (cmd == CMD_MRS) && dev_ready && rsv_hit;
        ok        = !busy && (cmd == CMD_MRS) && dev_ready && !rsv_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q        <= '0;
            mr_valid     <= 1'b0;
            reg_sel      <= SEL_MAIN;
            mrs_accept   <= 1'b0;
            err_state    <= 1'b0;
            err_timing   <= 1'b0;
            err_reserved <= 1'b0;
            warn_test    <= 1'b0;
        end else begin
            mrs_accept   <= ok;
            err_state    <= v_state;
            err_timing   <= v_timing;
            err_reserved <= v_rsv;
            warn_test    <= ok && (reg_sel_e'(ba[1:0]) == SEL_MAIN) && cfg_new.test_mode;
            if (ok) begin
                reg_sel <= ba[1:0];
                if (reg_sel_e'(ba[1:0]) == SEL_MAIN) begin
                    cfg_q    <= cfg_new;
                    mr_valid <= 1'b1;
                end
            end
        end
    end

    assign burst_len        = cfg_q.burst_len;
    assign burst_interleave = cfg_q.interleave;
    assign cas_latency      = cfg_q.cas_lat;
    assign write_recovery   = cfg_q.wr_cyc;
    assign dll_reset        = cfg_q.dll_reset;
    assign test_mode        = cfg_q.test_mode;
    assign pd_slow_exit     = cfg_q.pd_slow;
endmodule

// File: rtl/mrs_decoder_chk.sv
`timescale 1ns/1ps
module mrs_decoder_chk #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 mr_valid,
    input logic [3:0]           burst_len,
    input logic                 burst_interleave,
    input logic [3:0]           cas_latency,
    input logic [3:0]           write_recovery,
    input logic                 dll_reset,
    input logic                 test_mode,
    input logic                 pd_slow_exit,
    input logic [1:0]           reg_sel,
    input logic                 mrs_accept,
    input logic                 busy,
    input logic                 err_state,
    input logic                 err_timing,
    input logic                 err_reserved,
    input logic                 warn_test
);
    logic [15:0] cfg_bus;
    assign cfg_bus = {burst_len, burst_interleave, cas_latency, write_recovery,
                      dll_reset, test_mode, pd_slow_exit};

    a_r1_sel_moves_on_accept: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_sel) |-> mrs_accept);

    a_r2_accept_in_legal_state: assert property (@(posedge clk) disable iff (rst)
        mrs_accept |-> ($past(cke) && ($past(bank_open) == '0)));

    a_r3_busy_follows_accept: assert property (@(posedge clk) disable iff (rst)
        mrs_accept |-> busy);

    a_r3_timing_err_in_window: assert property (@(posedge clk) disable iff (rst)
        err_timing |-> $past(busy));

    a_r4_bl_legal: assert property (@(posedge clk) disable iff (rst)
        mr_valid |-> (burst_len == 4'd4 || burst_len == 4'd8));

    a_r6_cl_range: assert property (@(posedge clk) disable iff (rst)
        mr_valid |-> (cas_latency >= 4'd3 && cas_latency <= 4'd7));

    a_r7_wr_range: assert property (@(posedge clk) disable iff (rst)
        mr_valid |-> (write_recovery >= 4'd2 && write_recovery <= 4'd8));

    a_r8_warn_with_accept: assert property (@(posedge clk) disable iff (rst)
        warn_test |-> (mrs_accept && test_mode));

    a_r10_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        mr_valid |=> mr_valid);

    a_r11_no_busy_on_reserved: assert property (@(posedge clk) disable iff (rst)
        err_reserved |-> !mrs_accept);

    a_r12_cfg_moves_on_accept: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bus) |-> mrs_accept);

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mrs_accept, err_state, err_timing, err_reserved}));
endmodule

bind ddr2_mrs_decoder mrs_decoder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .cke              (cke),
    .bank_open        (bank_open),
    .mr_valid         (mr_valid),
    .burst_len        (burst_len),
    .burst_interleave (burst_interleave),
    .cas_latency      (cas_latency),
    .write_recovery   (write_recovery),
    .dll_reset        (dll_reset),
    .test_mode        (test_mode),
    .pd_slow_exit     (pd_slow_exit),
    .reg_sel          (reg_sel),
    .mrs_accept       (mrs_accept),
    .busy             (busy),
    .err_state        (err_state),
    .err_timing       (err_timing),
    .err_reserved     (err_reserved),
    .warn_test        (warn_test)
);

// File: tb/tb_ddr2_mrs_decoder.sv
`timescale 1ns/1ps
module tb_ddr2_mrs_decoder;
    localparam int NB   = 8;
    localparam int AW   = 14;
    localparam int BW   = 3;
    localparam int TM   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BW-1:0] ba = '0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] bank_open = '0;

    logic       mr_valid, burst_interleave, dll_reset, test_mode, pd_slow_exit;
    logic [3:0] burst_len, cas_latency, write_recovery;
    logic [1:0] reg_sel;
    logic       mrs_accept, busy, err_state, err_timing, err_reserved, warn_test;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ddr2_mrs_decoder #(.NUM_BANKS(NB), .ADDR_W(AW), .BANK_W(BW), .TMRD(TM)) dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
        .mr_valid(mr_valid), .burst_len(burst_len), .burst_interleave(burst_interleave),
        .cas_latency(cas_latency), .write_recovery(write_recovery), .dll_reset(dll_reset),
        .test_mode(test_mode), .pd_slow_exit(pd_slow_exit), .reg_sel(reg_sel),
        .mrs_accept(mrs_accept), .busy(busy), .err_state(err_state),
        .err_timing(err_timing), .err_reserved(err_reserved), .warn_test(warn_test)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] mk(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                                       input logic tm, input logic dll, input logic [2:0] wr,
                                       input logic pd, input logic a13);
        return {a13, pd, wr, dll, tm, cl, bt, bl};
    endfunction

    // drive one command for one edge, sample just after that edge, then deselect
    task automatic issue(input logic c, input logic r, input logic a, input logic w,
                         input logic [2:0] b, input logic [13:0] ad);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
        @(posedge clk);
        #1;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic mrs(input logic [2:0] b, input logic [13:0] ad);
        issue(1'b0, 1'b0, 1'b0, 1'b0, b, ad);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        check("R10", "mr_valid after reset", mr_valid, 0);
        check("R3", "busy after reset", busy, 0);
        check("R12", "no flags after reset", {mrs_accept, err_state, err_timing, err_reserved}, 0);
    endtask

    task automatic t_r2_state();
        bank_open = 8'b0010_0000;
        mrs(3'b000, mk(3'b011, 0, 3'b101, 0, 0, 3'b101, 0, 0));
        check("R2", "err_state bank open", err_state, 1);
        check("R2", "no accept bank open", mrs_accept, 0);
        check("R2", "mr_valid unchanged", mr_valid, 0);
        check("R2", "busy not started", busy, 0);
        bank_open = '0;
        cke = 1'b0;
        mrs(3'b000, mk(3'b011, 0, 3'b101, 0, 0, 3'b101, 0, 0));
        check("R2", "err_state cke low", err_state, 1);
        check("R2", "burst_len unchanged", burst_len, 0);
        cke = 1'b1;
    endtask

    task automatic t_main_write();
        int hi;
        mrs(3'b000, mk(3'b011, 0, 3'b101, 0, 0, 3'b101, 0, 0));
        check("R1", "accept main", mrs_accept, 1);
        check("R1", "reg_sel main", reg_sel, 0);
        check("R4", "burst_len 8", burst_len, 8);
        check("R5", "sequential", burst_interleave, 0);
        check("R6", "cas 5", cas_latency, 5);
        check("R7", "wr code5 -> 6", write_recovery, 6);
        check("R10", "mr_valid set", mr_valid, 1);
        check("R8", "no warn", warn_test, 0);
        hi = 1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1;
            if (busy) hi++;
            if (i == 0) check("R12", "accept is one pulse", mrs_accept, 0);
        end
        check("R3", "busy length = TMRD", hi, TM);
    endtask

    task automatic t_r3_timing();
        mrs(3'b000, mk(3'b010, 1, 3'b011, 0, 0, 3'b001, 1, 0));
        check("R1", "accept second write", mrs_accept, 1);
        check("R9", "slow exit", pd_slow_exit, 1);
        check("R4", "burst_len 4", burst_len, 4);
        check("R5", "interleave", burst_interleave, 1);
        check("R6", "cas 3", cas_latency, 3);
        check("R7", "wr code1 -> 2", write_recovery, 2);
        mrs(3'b000, mk(3'b011, 0, 3'b111, 0, 0, 3'b111, 0, 0));
        check("R3", "err_timing on MRS in window", err_timing, 1);
        check("R3", "not accepted in window", mrs_accept, 0);
        check("R3", "cas unchanged", cas_latency, 3);
        issue(1'b0, 1'b1, 1'b1, 1'b1, 3'b000, '0);
        check("R12", "err_timing one pulse", err_timing, 0);
        check("R3", "NOP in window no error", err_timing, 0);
        check("R3", "still busy at last window edge", busy, 1);
        @(posedge clk);
        #1;
        check("R3", "busy drops after TMRD", busy, 0);
        issue(1'b0, 1'b0, 1'b1, 1'b1, 3'b001, '0);
        check("R3", "other command after window no error", err_timing, 0);
    endtask

    task automatic t_r11_reserved();
        logic [13:0] bad [5];
        string       tag [5];
        bad[0] = mk(3'b000, 0, 3'b100, 0, 0, 3'b010, 0, 0); tag[0] = "R4";
        bad[1] = mk(3'b011, 0, 3'b010, 0, 0, 3'b010, 0, 0); tag[1] = "R6";
        bad[2] = mk(3'b011, 0, 3'b100, 0, 0, 3'b000, 0, 0); tag[2] = "R7";
        bad[3] = mk(3'b011, 0, 3'b100, 0, 0, 3'b010, 0, 1); tag[3] = "R9";
        bad[4] = mk(3'b011, 0, 3'b100, 0, 0, 3'b010, 0, 0); tag[4] = "R9";
        for (int k = 0; k < 5; k++) begin
            mrs((k == 4) ? 3'b100 : 3'b000, bad[k]);
            check(tag[k], "reserved flagged", err_reserved, 1);
            check("R11", "reserved not accepted", mrs_accept, 0);
            check("R11", "reserved no busy", busy, 0);
            check("R11", "cas unchanged", cas_latency, 3);
        end
        mrs(3'b110, '0);
        check("R9", "ba2 on extended flagged", err_reserved, 1);
        check("R11", "reg_sel unchanged", reg_sel, 0);
    endtask

    task automatic t_r8_bits();
        mrs(3'b000, mk(3'b011, 0, 3'b110, 1, 0, 3'b011, 0, 0));
        check("R8", "accept with test bit", mrs_accept, 1);
        check("R8", "warn_test", warn_test, 1);
        check("R8", "test_mode stored", test_mode, 1);
        wait_idle();
        mrs(3'b000, mk(3'b011, 1, 3'b110, 0, 1, 3'b011, 0, 0));
        check("R8", "no warn for dll", warn_test, 0);
        check("R8", "dll_reset stored", dll_reset, 1);
        check("R8", "test_mode cleared", test_mode, 0);
        wait_idle();
    endtask

    task automatic t_r10_ext();
        for (int e = 1; e < 4; e++) begin
            mrs(3'(e), 14'h0000);
            check("R1", "accept extended", mrs_accept, 1);
            check("R1", "reg_sel extended", reg_sel, e);
            check("R10", "main cas untouched", cas_latency, 6);
            check("R10", "main bl untouched", burst_len, 8);
            check("R10", "valid kept", mr_valid, 1);
            wait_idle();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_r2_state();
        t_main_write();
        t_r3_timing();
        t_r11_reserved();
        t_r8_bits();
        t_r10_ext();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule